// File: doc/BRIEF.md
# DS3 Loss-of-Frame Decision Monitor

This block watches an already bit-aligned DS3 receive stream and decides when frame alignment has been lost. Upstream logic slices the stream and, for each framing bit, multiframe-alignment bit and parity comparison, gives the block a one-cycle strobe and a flag that says whether the received value matched. The block keeps a sliding error history for each of the three kinds of bit. It declares loss of frame when any enabled criterion crosses its threshold while the framer is locked.

Three configuration bits set the criteria. The framing-bit rule is always active, and its select bit picks one of two thresholds. The multiframe rule can be switched on or off. The parity rule is switched on by the parity-framing bit, and that same bit also makes the block require good parity before it re-locks. When loss is declared, the block raises a registered out-of-frame output and the matching status bit, and it pulses a request for the acquisition logic to restart the framing-bit search. Both indications stay set until an external frame-found indication brings the block back into lock.

Top module: `ds3_oof_monitor`

## Requirements
- R1: After synchronous reset the block is in the search state: `in_frame`=0, `oof_out`=1, `search_req`=0, and `status` reads 8'h10, with configuration bits 3:0 cleared.
- R2: In search with parity framing off, `frame_found` sampled high at a clock edge sets `in_frame`=1 and `oof_out`=0 from that edge on.
- R3: With parity framing on (status bit 2 = 1), `frame_found` only re-locks if `parity_good` is also high at the same edge.
- R4: With the framing-bit select at 0 (status bit 1), loss is declared once 6 of the last 16 framing-bit strobes were errors (`f_match`=0). Five errors are not enough.
- R5: With the framing-bit select at 1, loss is declared once 3 of the last 16 framing-bit strobes were errors.
- R6: Each history is a sliding window. An error older than the last window-length strobes of its kind no longer counts.
- R7: With the multiframe select at 0 (status bit 0), errors on `m_valid` strobes never cause loss of frame.
- R8: With the multiframe select at 1, loss is declared once 3 of the last 4 multiframe-bit strobes were errors.
- R9: With parity framing on, loss is declared once 2 of the last 5 parity strobes were errors. With it off, parity errors have no effect.
- R10: A declaration takes effect at the clock edge after the error that crosses the threshold was strobed. At that edge `in_frame` falls, `oof_out` and status bit 4 go to 1, and `search_req` is high for exactly one cycle. `oof_out` then stays high until re-lock.
- R11: Status bits 3:0 read back the last written configuration. Bits 5, 6 and 7 show `idle_in`, `los_in` and `ais_in` one clock after they are sampled.
- R12: All histories are cleared whenever the block is out of lock, so errors seen before a loss do not count after re-lock.
- R13: The histories advance only on their own strobe. A `*_match` value presented without its strobe has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for configuration bits |
| cfg_wdata | input | 4 | {LOS disable, parity framing, framing-bit select, multiframe select} |
| f_valid | input | 1 | Framing-bit comparison available |
| f_match | input | 1 | Framing bit matched (0 = error) |
| m_valid | input | 1 | Multiframe-bit comparison available |
| m_match | input | 1 | Multiframe bit matched (0 = error) |
| p_valid | input | 1 | Per-multiframe parity comparison available |
| p_match | input | 1 | Parity matched (0 = error) |
| frame_found | input | 1 | Acquisition logic has found alignment |
| parity_good | input | 1 | Parity valid for re-lock |
| idle_in | input | 1 | Idle indication for status bit 5 |
| los_in | input | 1 | Loss-of-signal indication for status bit 6 |
| ais_in | input | 1 | Alarm indication for status bit 7 |
| oof_out | output | 1 | Out-of-frame, registered |
| in_frame | output | 1 | Locked state |
| search_req | output | 1 | One-cycle request to restart framing-bit search |
| status | output | 8 | {ais, los, idle, oof, cfg[3:0]} |

## Verification
The bench builds the block with its default windows: 16 framing bits with thresholds 6 and 3, 4 multiframe bits with threshold 3, and 5 parity results with threshold 2. With these sizes every threshold and every slide-out can be reached in 20 strobes or fewer. The vector table includes just-below and exactly-at cases for each threshold, and patterns where the errors are spread out so that only a true sliding window keeps the count below threshold.

// File: rtl/ds3_oof_pkg.sv
package ds3_oof_pkg;
  typedef enum logic {
    ST_SEARCH  = 1'b0,
    ST_LOCKED  = 1'b1
  } lock_state_e;

  localparam int CFG_BITS    = 4;
  localparam int CFG_MSEL    = 0;
  localparam int CFG_FSEL    = 1;
  localparam int CFG_PARFRM  = 2;
  localparam int CFG_LOSDIS  = 3;
endpackage

// File: rtl/ds3_err_window.sv
module ds3_err_window #(
  parameter  int DEPTH = 16,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          adv,
  input  logic          err,
  output logic [CW-1:0] cnt
);
  logic [DEPTH-1:0] hist;

  always_ff @(posedge clk) begin
    if (clr)      hist <= '0;
    else if (adv) hist <= {hist[DEPTH-2:0], err};
  end

  always_comb begin
    cnt = '0;
    for (int i = 0; i < DEPTH; i++) cnt = cnt + CW'(hist[i]);
  end
endmodule

// File: rtl/ds3_lock_fsm.sv
module ds3_lock_fsm
  import ds3_oof_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic relock,
  input  logic lose,
  output logic in_frame,
  output logic oof,
  output logic search_req
);
  lock_state_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_SEARCH;
      oof        <= 1'b1;
      search_req <= 1'b0;
    end else begin
      search_req <= 1'b0;
      case (state)
        ST_SEARCH: if (relock) begin
          state <= ST_LOCKED;
          oof   <= 1'b0;
        end
        ST_LOCKED: if (lose) begin
          state      <= ST_SEARCH;
          oof        <= 1'b1;
          search_req <= 1'b1;
        end
        default: state <= ST_SEARCH;
      endcase
    end
  end

  assign in_frame = (state == ST_LOCKED);
endmodule

// File: rtl/ds3_oof_monitor.sv
module ds3_oof_monitor
  import ds3_oof_pkg::*;
#(
  parameter int F_WIN      = 16,
  parameter int F_THR_NORM = 6,
  parameter int F_THR_FAST = 3,
  parameter int M_WIN      = 4,
  parameter int M_THR      = 3,
  parameter int P_WIN      = 5,
  parameter int P_THR      = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_we,
  input  logic [3:0] cfg_wdata,
  input  logic       f_valid,
  input  logic       f_match,
  input  logic       m_valid,
  input  logic       m_match,
  input  logic       p_valid,
  input  logic       p_match,
  input  logic       frame_found,
  input  logic       parity_good,
  input  logic       idle_in,
  input  logic       los_in,
  input  logic       ais_in,
  output logic       oof_out,
  output logic       in_frame,
  output logic       search_req,
  output logic [7:0] status
);
  localparam int FCW = $clog2(F_WIN + 1);
  localparam int MCW = $clog2(M_WIN + 1);
  localparam int PCW = $clog2(P_WIN + 1);
  localparam logic [FCW-1:0] F_T_NORM = FCW'(F_THR_NORM);
  localparam logic [FCW-1:0] F_T_FAST = FCW'(F_THR_FAST);
  localparam logic [MCW-1:0] M_T      = MCW'(M_THR);
  localparam logic [PCW-1:0] P_T      = PCW'(P_THR);

  logic [CFG_BITS-1:0] cfg_q;
  logic [2:0]          ro_q;
  logic [FCW-1:0]      f_cnt;
  logic [MCW-1:0]      m_cnt;
  logic [PCW-1:0]      p_cnt;
  logic                win_clr, f_hit, m_hit, p_hit, lose, relock;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      ro_q  <= '0;
    end else begin
      if (cfg_we) cfg_q <= cfg_wdata;
      ro_q <= {ais_in, los_in, idle_in};
    end
  end

  assign win_clr = rst | ~in_frame;

  ds3_err_window #(.DEPTH(F_WIN)) u_fwin (
    .clk(clk), .clr(win_clr), .adv(f_valid), .err(~f_match), .cnt(f_cnt));
  ds3_err_window #(.DEPTH(M_WIN)) u_mwin (
    .clk(clk), .clr(win_clr), .adv(m_valid), .err(~m_match), .cnt(m_cnt));
  ds3_err_window #(.DEPTH(P_WIN)) u_pwin (
    .clk(clk), .clr(win_clr), .adv(p_valid), .err(~p_match), .cnt(p_cnt));

  assign f_hit  = f_cnt >= (cfg_q[CFG_FSEL] ? F_T_FAST : F_T_NORM);
  assign m_hit  = cfg_q[CFG_MSEL]   && (m_cnt >= M_T);
  assign p_hit  = cfg_q[CFG_PARFRM] && (p_cnt >= P_T);
  assign lose   = f_hit | m_hit | p_hit;
  assign relock = frame_found && (!cfg_q[CFG_PARFRM] || parity_good);

  ds3_lock_fsm u_fsm (
    .clk(clk), .rst(rst), .relock(relock), .lose(lose),
    .in_frame(in_frame), .oof(oof_out), .search_req(search_req));

  assign status = {ro_q, oof_out, cfg_q};
endmodule

// File: rtl/ds3_oof_checker.sv
module ds3_oof_checker #(
  parameter  int F_WIN = 16,
  parameter  int M_WIN = 4,
  parameter  int P_WIN = 5,
  localparam int FCW   = $clog2(F_WIN + 1),
  localparam int MCW   = $clog2(M_WIN + 1),
  localparam int PCW   = $clog2(P_WIN + 1)
) (
  input logic           clk,
  input logic           rst,
  input logic           in_frame,
  input logic           oof_out,
  input logic           search_req,
  input logic           frame_found,
  input logic           parity_good,
  input logic           par_frm,
  input logic [FCW-1:0] f_cnt,
  input logic [MCW-1:0] m_cnt,
  input logic [PCW-1:0] p_cnt
);
  // R10: restart request only on a locked-to-search transition
  a_r10_req_on_loss: assert property (@(posedge clk) disable iff (rst)
    search_req |-> (!in_frame && $past(in_frame)));
  // R10: request lasts one cycle
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    search_req |=> !search_req);
  // R10: out-of-frame output is the complement of lock
  a_r10_oof_vs_lock: assert property (@(posedge clk) disable iff (rst)
    oof_out == !in_frame);
  // R2: lock needs frame_found
  a_r2_lock_needs_found: assert property (@(posedge clk) disable iff (rst)
    $rose(in_frame) |-> $past(frame_found));
  // R3: parity framing needs good parity to lock
  a_r3_lock_needs_parity: assert property (@(posedge clk) disable iff (rst)
    ($rose(in_frame) && $past(par_frm)) |-> $past(parity_good));
  // R12: histories empty on entry to lock
  a_r12_clear_on_entry: assert property (@(posedge clk) disable iff (rst)
    $rose(in_frame) |-> (f_cnt == '0 && m_cnt == '0 && p_cnt == '0));
  // R6: counts never exceed window length
  a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
    (f_cnt <= FCW'(F_WIN)) && (m_cnt <= MCW'(M_WIN)) && (p_cnt <= PCW'(P_WIN)));
endmodule

bind ds3_oof_monitor ds3_oof_checker #(
  .F_WIN(F_WIN), .M_WIN(M_WIN), .P_WIN(P_WIN)
) chk (
  .clk(clk), .rst(rst), .in_frame(in_frame), .oof_out(oof_out),
  .search_req(search_req), .frame_found(frame_found),
  .parity_good(parity_good), .par_frm(cfg_q[2]),
  .f_cnt(f_cnt), .m_cnt(m_cnt), .p_cnt(p_cnt)
);

// File: tb/ds3_oof_monitor_test.sv
module ds3_oof_monitor_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_wdata = '0;
  logic       f_valid = 0, f_match = 1, m_valid = 0, m_match = 1;
  logic       p_valid = 0, p_match = 1;
  logic       frame_found = 0, parity_good = 0;
  logic       idle_in = 0, los_in = 0, ais_in = 0;
  logic       oof_out, in_frame, search_req;
  logic [7:0] status;
  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  ds3_oof_monitor uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .f_valid(f_valid), .f_match(f_match), .m_valid(m_valid), .m_match(m_match),
    .p_valid(p_valid), .p_match(p_match), .frame_found(frame_found),
    .parity_good(parity_good), .idle_in(idle_in), .los_in(los_in),
    .ais_in(ais_in), .oof_out(oof_out), .in_frame(in_frame),
    .search_req(search_req), .status(status));

  // kind: 0 framing bit, 1 multiframe bit, 2 parity; pat bit b = error on strobe b
  typedef struct packed {
    logic        fsel;
    logic        msel;
    logic        pfrm;
    logic [1:0]  kind;
    logic [4:0]  n;
    logic [19:0] pat;
    logic        exp_oof;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 1'b0, 2'd0, 5'd16, 20'h0001F, 1'b0},  // R4 five of 16
    '{1'b0, 1'b0, 1'b0, 2'd0, 5'd6,  20'h0003F, 1'b1},  // R4 six
    '{1'b0, 1'b0, 1'b0, 2'd0, 5'd16, 20'h0AAA0, 1'b1},  // R4 six spread
    '{1'b1, 1'b0, 1'b0, 2'd0, 5'd16, 20'h00003, 1'b0},  // R5 two
    '{1'b1, 1'b0, 1'b0, 2'd0, 5'd3,  20'h00007, 1'b1},  // R5 three
    '{1'b1, 1'b0, 1'b0, 2'd0, 5'd20, 20'hC0003, 1'b0},  // R6 slide out
    '{1'b1, 1'b0, 1'b0, 2'd0, 5'd17, 20'h1C000, 1'b1},  // R6 late three
    '{1'b0, 1'b0, 1'b0, 2'd1, 5'd4,  20'h0000F, 1'b0},  // R7 ignored
    '{1'b0, 1'b1, 1'b0, 2'd1, 5'd4,  20'h0000B, 1'b1},  // R8 three of four
    '{1'b0, 1'b1, 1'b0, 2'd1, 5'd4,  20'h00009, 1'b0},  // R8 two of four
    '{1'b0, 1'b1, 1'b0, 2'd1, 5'd6,  20'h00025, 1'b0},  // R8/R6 sliding
    '{1'b0, 1'b0, 1'b1, 2'd2, 5'd5,  20'h00011, 1'b1},  // R9 two of five
    '{1'b0, 1'b0, 1'b1, 2'd2, 5'd6,  20'h00021, 1'b0},  // R9 outside window
    '{1'b0, 1'b0, 1'b0, 2'd2, 5'd5,  20'h0001F, 1'b0}   // R9 disabled
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic write_cfg(input logic [3:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic lock_up();
    @(negedge clk); frame_found = 1'b1; parity_good = 1'b1;
    @(negedge clk); frame_found = 1'b0; parity_good = 1'b0;
  endtask

  task automatic strobe(input logic [1:0] kind, input logic err);
    @(negedge clk);
    case (kind)
      2'd0:    begin f_valid = 1'b1; f_match = ~err; end
      2'd1:    begin m_valid = 1'b1; m_match = ~err; end
      default: begin p_valid = 1'b1; p_match = ~err; end
    endcase
    @(negedge clk);
    f_valid = 0; m_valid = 0; p_valid = 0;
    f_match = 1; m_match = 1; p_match = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 status", status, 8'h10);
    check("R1 lock/oof/req", {5'd0, in_frame, oof_out, search_req}, 8'h02);

    // R2 lock entry
    lock_up();
    check("R2 locked", {6'd0, in_frame, oof_out}, 8'h02);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      do_reset();
      write_cfg({1'b0, VEC[v].pfrm, VEC[v].fsel, VEC[v].msel});
      lock_up();
      for (int b = 0; b < int'(VEC[v].n); b++) strobe(VEC[v].kind, VEC[v].pat[b]);
      @(negedge clk);
      check($sformatf("R4-R9 vec%0d oof", v), {7'd0, oof_out}, {7'd0, VEC[v].exp_oof});
      check($sformatf("R10 vec%0d status4", v), {7'd0, status[4]}, {7'd0, VEC[v].exp_oof});
    end

    // R3 parity framing blocks lock without good parity
    do_reset();
    write_cfg(4'b0100);
    @(negedge clk); frame_found = 1'b1; parity_good = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R3 no lock", {7'd0, in_frame}, 8'h00);
    parity_good = 1'b1;
    @(negedge clk); frame_found = 1'b0; parity_good = 1'b0;
    check("R3 lock", {7'd0, in_frame}, 8'h01);

    // R10 timing and stickiness
    do_reset();
    write_cfg(4'b0010);
    lock_up();
    strobe(2'd0, 1'b1); strobe(2'd0, 1'b1); strobe(2'd0, 1'b1);
    check("R10 not yet", {6'd0, oof_out, search_req}, 8'h00);
    @(negedge clk);
    check("R10 declare", {5'd0, in_frame, oof_out, search_req}, 8'h03);
    check("R10 status4", {7'd0, status[4]}, 8'h01);
    @(negedge clk);
    check("R10 pulse end", {5'd0, in_frame, oof_out, search_req}, 8'h02);
    repeat (5) @(negedge clk);
    check("R10 sticky", {7'd0, oof_out}, 8'h01);

    // R11 status layout
    write_cfg(4'b1011);
    @(negedge clk); idle_in = 1; los_in = 0; ais_in = 1;
    @(negedge clk);
    check("R11 status", status, 8'b1011_1011);
    idle_in = 0; ais_in = 0;

    // R12 histories cleared across loss
    do_reset();
    write_cfg(4'b0011);
    lock_up();
    strobe(2'd0, 1'b1); strobe(2'd0, 1'b1);
    strobe(2'd1, 1'b1); strobe(2'd1, 1'b1); strobe(2'd1, 1'b1);
    @(negedge clk);
    check("R12 lost via M", {7'd0, oof_out}, 8'h01);
    lock_up();
    strobe(2'd0, 1'b1);
    @(negedge clk);
    check("R12 no carryover", {7'd0, oof_out}, 8'h00);

    // R13 match without strobe ignored
    do_reset();
    write_cfg(4'b0010);
    lock_up();
    @(negedge clk); f_match = 0; m_match = 0; p_match = 0;
    repeat (10) @(negedge clk);
    f_match = 1; m_match = 1; p_match = 1;
    strobe(2'd0, 1'b1); strobe(2'd0, 1'b1);
    @(negedge clk);
    check("R13 no phantom", {7'd0, oof_out}, 8'h00);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule